// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Controller

This block is a synchronous controller that turns digital supply-status flags into a timed processor reset. It also raises a watchdog fault when software stops servicing it. Two flags arrive from analog comparators outside the block:

- a low-supply flag, set when the supply is under the reset threshold;
- a backup flag, set when the supply is under the backup battery voltage.

While either flag is set, reset is held and the memory chip-enable is blocked. Once both clear, reset stays asserted for a fixed hold time and is then released.

After release, a watchdog watches a service input. Either edge of that input restarts the count. A separate qualifier marks the input as floating, which disables the watchdog. Right after any reset the timeout is long. Once the first service edge is seen, the shorter normal timeout applies. A timeout latches a fault output low and fires a new reset pulse. While the input stays idle, such a pulse repeats once per long timeout.

All timing advances only on a timebase tick enable. A mode input picks one of two sets of tick counts: one for an external clock and one for the internal timebase. In the internal set, a period select chooses between two normal timeouts.

Top module: `sw_supervisor`

## Requirements
- R1: Reset is asserted (`rst_n_o` low) in every cycle after a clock edge that sampled `low_line_i` or `batt_mode_i` high, and while the synchronous `rst` is applied.
- R2: When both supply flags are low, reset stays asserted for exactly RST_LEN ticks. Only cycles with `tick_en` high count. RST_LEN is EXT_RST when `ext_mode` is 1 and INT_RST when it is 0. `rst_n_o` rises on the edge that takes the last tick. The hold also runs after the synchronous `rst` is released.
- R3: After any release of reset, the watchdog timeout is the long value (EXT_LONG, or INT_LONG) until the first service edge is seen.
- R4: After the first service edge, the timeout is the short value. It is EXT_SHORT when `ext_mode` is 1. When `ext_mode` is 0, it is INT_SHORT if `short_sel` is 1 and INT_LONG if `short_sel` is 0.
- R5: A rising edge and a falling edge of `wd_in` both restart the timeout count. An edge takes effect on the third clock edge after `wd_in` changes, because it passes two synchroniser stages first.
- R6: A timeout drops `rst_n_o` for a full RST_LEN hold. With no service edges, such a pulse recurs after every long timeout.
- R7: `wd_fault_n_o` goes low on a timeout and stays low until the next service edge. It is 1 after reset and in every cycle after a supply flag was sampled high.
- R8: While `wd_float` is high, no timeout occurs and edges are ignored; the count restarts from zero when it returns low.
- R9: `ce_out_o` equals `ce_in_i` while both supply flags are low. It is 1 whenever either flag is high.
- R10: `rst_o` is always the complement of `rst_n_o`, including while `rst` is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Timebase tick; timers advance only when high |
| ext_mode | input | 1 | 1 selects external-clock tick counts, 0 selects internal-timebase counts |
| short_sel | input | 1 | Internal mode only: 1 short normal timeout, 0 long normal timeout |
| low_line_i | input | 1 | Supply below reset threshold |
| batt_mode_i | input | 1 | Supply below backup battery |
| wd_in | input | 1 | Watchdog service input (asynchronous) |
| wd_float | input | 1 | Service input is floating; disables the watchdog |
| ce_in_i | input | 1 | Memory chip-enable from the decoder |
| rst_n_o | output | 1 | Processor reset, active low |
| rst_o | output | 1 | Processor reset, active high |
| wd_fault_n_o | output | 1 | Watchdog fault, active low, latched |
| ce_out_o | output | 1 | Gated chip-enable, forced high when supply is bad |

## Verification
A counter that is wrong by one shows up as `rst_n_o` rising one tick early or late at the end of a hold. It also shows up as a reset pulse whose start is shifted against the last service edge, so it appears within one hold or timeout window. A stale long/short flag is different: it shows only when a service stream stops. The next reset then comes after the wrong period. That is why the idle intervals follow both long and short regimes in both timing modes. A latched fault bit that fails to clear stays visible on `wd_fault_n_o` from the first edge after a timeout onward.

// File: rtl/sw_pkg.sv
`timescale 1ns/1ps
package sw_pkg;

    // Width of every timing limit carried between blocks.
    localparam int LIM_W = 16;

    typedef logic [LIM_W-1:0] lim_t;

    typedef enum logic [1:0] {
        PH_HOLD  = 2'd0,   // supply bad, reset held
        PH_PULSE = 2'd1,   // reset hold time running
        PH_RUN   = 2'd2    // reset released, watchdog active
    } phase_e;

    typedef struct packed {
        lim_t rst_len;     // reset hold length in ticks
        lim_t wd_short;    // normal watchdog timeout
        lim_t wd_long;     // post-reset watchdog timeout
    } lims_t;

    // True when the tick now being taken is the last one of a window.
    function automatic logic last_tick(lim_t cnt, lim_t lim);
        return (cnt + lim_t'(1)) >= lim;
    endfunction

endpackage

// File: rtl/sw_edge_sync.sv
`timescale 1ns/1ps
module sw_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    input  logic en,
    output logic edge_o
);
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q[0] <= 1'b0;
        else     chain_q[0] <= din;
    end

    for (genvar i = 1; i <= STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain_q[i] <= 1'b0;
            else     chain_q[i] <= chain_q[i-1];
        end
    end

    // One-cycle pulse on either polarity of the synchronised level.
    assign edge_o = en & (chain_q[STAGES-1] ^ chain_q[STAGES]);

endmodule

// File: rtl/sw_limits.sv
`timescale 1ns/1ps
module sw_limits
    import sw_pkg::*;
#(
    parameter int EXT_RST   = 2048,
    parameter int EXT_SHORT = 1024,
    parameter int EXT_LONG  = 4096,
    parameter int INT_RST   = 2048,
    parameter int INT_SHORT = 1024,
    parameter int INT_LONG  = 16384
) (
    input  logic  ext_mode,
    input  logic  short_sel,
    output lims_t lims
);
    localparam lim_t L_EXT_RST   = lim_t'(EXT_RST);
    localparam lim_t L_EXT_SHORT = lim_t'(EXT_SHORT);
    localparam lim_t L_EXT_LONG  = lim_t'(EXT_LONG);
    localparam lim_t L_INT_RST   = lim_t'(INT_RST);
    localparam lim_t L_INT_SHORT = lim_t'(INT_SHORT);
    localparam lim_t L_INT_LONG  = lim_t'(INT_LONG);

    always_comb begin
        if (ext_mode) begin
            lims.rst_len  = L_EXT_RST;
            lims.wd_short = L_EXT_SHORT;
            lims.wd_long  = L_EXT_LONG;
        end else begin
            lims.rst_len  = L_INT_RST;
            lims.wd_short = short_sel ? L_INT_SHORT : L_INT_LONG;
            lims.wd_long  = L_INT_LONG;
        end
    end

endmodule

// File: rtl/sw_core.sv
`timescale 1ns/1ps
module sw_core
    import sw_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  logic  bad,
    input  logic  wd_float,
    input  logic  wd_edge,
    input  lims_t lims,
    output logic  rst_n_o,
    output logic  fault_n_o
);
    phase_e           ph_q,   ph_d;
    logic [CNT_W-1:0] cnt_q,  cnt_d;
    logic             long_q, long_d;
    logic             flt_q,  flt_d;
    lim_t             cnt_ext;
    lim_t             wd_lim;

    assign cnt_ext = lim_t'(cnt_q);
    assign wd_lim  = long_q ? lims.wd_long : lims.wd_short;

    always_comb begin
        ph_d   = ph_q;
        cnt_d  = cnt_q;
        long_d = long_q;
        flt_d  = flt_q;
        if (bad) begin
            ph_d   = PH_HOLD;
            cnt_d  = '0;
            long_d = 1'b1;
            flt_d  = 1'b1;
        end else begin
            unique case (ph_q)
                PH_HOLD: begin
                    ph_d   = PH_PULSE;
                    cnt_d  = '0;
                    long_d = 1'b1;
                end
                PH_PULSE: begin
                    if (wd_edge) flt_d = 1'b1;
                    if (tick) begin
                        if (last_tick(cnt_ext, lims.rst_len)) begin
                            ph_d  = PH_RUN;
                            cnt_d = '0;
                        end else begin
                            cnt_d = cnt_q + CNT_W'(1);
                        end
                    end
                end
                PH_RUN: begin
                    if (wd_float) begin
                        cnt_d = '0;
                    end else if (wd_edge) begin
                        cnt_d  = '0;
                        long_d = 1'b0;
                        flt_d  = 1'b1;
                    end else if (tick) begin
                        if (last_tick(cnt_ext, wd_lim)) begin
                            ph_d   = PH_PULSE;
                            cnt_d  = '0;
                            long_d = 1'b1;
                            flt_d  = 1'b0;
                        end else begin
                            cnt_d = cnt_q + CNT_W'(1);
                        end
                    end
                end
                default: ph_d = PH_HOLD;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_PULSE;
            cnt_q  <= '0;
            long_q <= 1'b1;
            flt_q  <= 1'b1;
        end else begin
            ph_q   <= ph_d;
            cnt_q  <= cnt_d;
            long_q <= long_d;
            flt_q  <= flt_d;
        end
    end

    assign rst_n_o   = (ph_q == PH_RUN);
    assign fault_n_o = flt_q;

endmodule

// File: rtl/sw_supervisor.sv
`timescale 1ns/1ps
module sw_supervisor
    import sw_pkg::*;
#(
    parameter int CNT_W       = 14,
    parameter int SYNC_STAGES = 2,
    parameter int EXT_RST     = 2048,
    parameter int EXT_SHORT   = 1024,
    parameter int EXT_LONG    = 4096,
    parameter int INT_RST     = 2048,
    parameter int INT_SHORT   = 1024,
    parameter int INT_LONG    = 16384
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_en,
    input  logic ext_mode,
    input  logic short_sel,
    input  logic low_line_i,
    input  logic batt_mode_i,
    input  logic wd_in,
    input  logic wd_float,
    input  logic ce_in_i,
    output logic rst_n_o,
    output logic rst_o,
    output logic wd_fault_n_o,
    output logic ce_out_o
);
    logic  bad;
    logic  wd_edge;
    lims_t lims;
    logic  rst_n_w;

    assign bad = low_line_i | batt_mode_i;

    sw_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .din    (wd_in),
        .en     (~wd_float),
        .edge_o (wd_edge)
    );

    sw_limits #(
        .EXT_RST  (EXT_RST),
        .EXT_SHORT(EXT_SHORT),
        .EXT_LONG (EXT_LONG),
        .INT_RST  (INT_RST),
        .INT_SHORT(INT_SHORT),
        .INT_LONG (INT_LONG)
    ) u_lims (
        .ext_mode (ext_mode),
        .short_sel(short_sel),
        .lims     (lims)
    );

    sw_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_en),
        .bad      (bad),
        .wd_float (wd_float),
        .wd_edge  (wd_edge),
        .lims     (lims),
        .rst_n_o  (rst_n_w),
        .fault_n_o(wd_fault_n_o)
    );

    assign rst_n_o  = rst_n_w;
    assign rst_o    = ~rst_n_w;
    assign ce_out_o = bad | ce_in_i;   // write blocking while supply is bad

endmodule

// File: rtl/sw_supervisor_chk.sv
`timescale 1ns/1ps
module sw_supervisor_chk (
    input logic clk,
    input logic rst,
    input logic low_line_i,
    input logic batt_mode_i,
    input logic rst_n_o,
    input logic wd_fault_n_o,
    input logic ce_out_o
);
    assert_hold_while_bad_R1: assert property (@(posedge clk) disable iff (rst)
        (low_line_i || batt_mode_i) |=> !rst_n_o);

    assert_release_only_when_good_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_n_o) |-> !$past(low_line_i || batt_mode_i));

    assert_fault_starts_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(wd_fault_n_o) |-> !rst_n_o);

    assert_fault_cleared_when_bad_R7: assert property (@(posedge clk) disable iff (rst)
        (low_line_i || batt_mode_i) |=> wd_fault_n_o);

    assert_ce_blocked_R9: assert property (@(posedge clk) disable iff (rst)
        (low_line_i || batt_mode_i) |-> ce_out_o);
endmodule

bind sw_supervisor sw_supervisor_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .low_line_i  (low_line_i),
    .batt_mode_i (batt_mode_i),
    .rst_n_o     (rst_n_o),
    .wd_fault_n_o(wd_fault_n_o),
    .ce_out_o    (ce_out_o)
);

// File: tb/sw_supervisor_bench.sv
`timescale 1ns/1ps
module sw_supervisor_bench;
    localparam int P_EXT_RST = 10, P_EXT_SHORT = 8,  P_EXT_LONG = 30;
    localparam int P_INT_RST = 12, P_INT_SHORT = 6,  P_INT_LONG = 40;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst = 1'b1, tick_en = 1'b1, ext_mode = 1'b1, short_sel = 1'b1;
    logic low_line_i = 1'b0, batt_mode_i = 1'b0, wd_in = 1'b0, wd_float = 1'b0, ce_in_i = 1'b0;
    logic rst_n_o, rst_o, wd_fault_n_o, ce_out_o;

    sw_supervisor #(
        .CNT_W(8), .SYNC_STAGES(2),
        .EXT_RST(P_EXT_RST), .EXT_SHORT(P_EXT_SHORT), .EXT_LONG(P_EXT_LONG),
        .INT_RST(P_INT_RST), .INT_SHORT(P_INT_SHORT), .INT_LONG(P_INT_LONG)
    ) u_sw_supervisor (
        .clk(clk), .rst(rst), .tick_en(tick_en), .ext_mode(ext_mode),
        .short_sel(short_sel), .low_line_i(low_line_i), .batt_mode_i(batt_mode_i),
        .wd_in(wd_in), .wd_float(wd_float), .ce_in_i(ce_in_i),
        .rst_n_o(rst_n_o), .rst_o(rst_o), .wd_fault_n_o(wd_fault_n_o), .ce_out_o(ce_out_o)
    );

    // ---------------- behavioural reference ----------------
    int  vectors = 0, errors = 0, cyc = 0;
    int  m_phase = 1;          // 0 held by supply, 1 hold time, 2 running
    int  m_cnt = 0;
    bit  m_long = 1, m_fault = 1, m_from_wd = 0, m_edge_seen = 0, started = 0;
    bit  wd_hist[$];           // samples of wd_in, newest at back

    function automatic int rst_len();
        return ext_mode ? P_EXT_RST : P_INT_RST;
    endfunction
    function automatic int wd_len(bit lng);
        if (lng) return ext_mode ? P_EXT_LONG : P_INT_LONG;
        if (ext_mode) return P_EXT_SHORT;
        return short_sel ? P_INT_SHORT : P_INT_LONG;
    endfunction

    always @(posedge clk) begin
        bit svc, bad;
        bad = low_line_i | batt_mode_i;
        svc = 0;
        if (wd_hist.size() >= 3)
            svc = (wd_hist[wd_hist.size()-2] != wd_hist[wd_hist.size()-3]) && !wd_float;
        m_edge_seen = 0;
        if (rst) begin
            m_phase = 1; m_cnt = 0; m_long = 1; m_fault = 1; m_from_wd = 0;
            wd_hist.delete();
            wd_hist.push_back(0); wd_hist.push_back(0); wd_hist.push_back(0);
        end else begin
            if (bad) begin
                m_phase = 0; m_cnt = 0; m_long = 1; m_fault = 1; m_from_wd = 0;
            end else if (m_phase == 0) begin
                m_phase = 1; m_cnt = 0; m_long = 1;
            end else if (m_phase == 1) begin
                if (svc) m_fault = 1;
                if (tick_en) begin
                    if (m_cnt + 1 >= rst_len()) begin m_phase = 2; m_cnt = 0; m_from_wd = 0; end
                    else m_cnt++;
                end
            end else begin
                if (wd_float) m_cnt = 0;
                else if (svc) begin m_cnt = 0; m_long = 0; m_fault = 1; m_edge_seen = 1; end
                else if (tick_en) begin
                    if (m_cnt + 1 >= wd_len(m_long)) begin
                        m_phase = 1; m_cnt = 0; m_fault = 0; m_long = 1; m_from_wd = 1;
                    end else m_cnt++;
                end
            end
            wd_hist.push_back(wd_in);
            if (wd_hist.size() > 8) void'(wd_hist.pop_front());
        end
        started = 1;
    end

    function automatic string ctx();
        if (rst || low_line_i || batt_mode_i || m_phase == 0) return "R1";
        if (m_phase == 1) return m_from_wd ? "R6" : "R2";
        if (wd_float) return "R8";
        if (m_edge_seen) return "R5";
        return m_long ? "R3" : "R4";
    endfunction

    always @(negedge clk) begin
        if (started) begin
            bit exp_rn, exp_ce;
            exp_rn = (m_phase == 2);
            exp_ce = low_line_i | batt_mode_i | ce_in_i;
            vectors++;
            if (rst_n_o !== exp_rn) begin
                errors++;
                $display("FAIL %s rst_n_o act=%0b exp=%0b cyc=%0d", ctx(), rst_n_o, exp_rn, cyc);
            end
            if (rst_o !== !exp_rn) begin
                errors++;
                $display("FAIL R10 rst_o act=%0b exp=%0b cyc=%0d", rst_o, !exp_rn, cyc);
            end
            if (wd_fault_n_o !== m_fault) begin
                errors++;
                $display("FAIL R7 wd_fault_n_o act=%0b exp=%0b cyc=%0d", wd_fault_n_o, m_fault, cyc);
            end
            if (ce_out_o !== exp_ce) begin
                errors++;
                $display("FAIL R9 ce_out_o act=%0b exp=%0b cyc=%0d", ce_out_o, exp_ce, cyc);
            end
        end
    end

    // ---------------- stimulus ----------------
    bit tick_gap = 0;
    int tog_per = 0;

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            cyc++;
            tick_en = tick_gap ? ((cyc % 3) != 0) : 1'b1;
            if (tog_per > 0 && (cyc % tog_per) == 0) wd_in = ~wd_in;
            ce_in_i = ((cyc / 3) % 2) == 1;
        end
    endtask

    initial begin
        run(3);
        rst = 0;
        run(90);                              // R2 hold, R3 long idle, R6 repeat
        tick_gap = 1; run(120); tick_gap = 0; // R2 ticks gate the count
        tog_per = 5; run(80);                 // R5 service, R4 short, R7 clear
        tog_per = 0; run(50);                 // R4 short timeout then R6
        tog_per = 3; run(20);
        wd_float = 1; run(120);               // R8 disabled
        wd_float = 0; run(60);
        low_line_i = 1; run(15); low_line_i = 0; run(5);   // R1, R9
        batt_mode_i = 1; run(10); batt_mode_i = 0; run(4);
        low_line_i = 1; batt_mode_i = 1; run(6); low_line_i = 0; batt_mode_i = 0;
        run(40);
        ext_mode = 0; short_sel = 1;
        low_line_i = 1; run(3); low_line_i = 0;
        tog_per = 4; run(100);                // internal short
        tog_per = 0; run(60);
        short_sel = 0; tog_per = 7; run(100); // internal long normal
        tog_per = 0; run(130);
        tog_per = 2; run(40);
        rst = 1; run(2); rst = 0; run(40);    // R10 during reset
        ext_mode = 1; tog_per = 6; run(60); tog_per = 0; run(50);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #(150000 * 5);
        errors++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule